// File: doc/BRIEF.md
# Configurable Registered I/O Macrocell Pair

This block is the I/O cell of a programmable state-machine fabric, built as an array of cell pairs. Each cell holds a state register and an input register, and six static configuration bits per cell choose the architecture around them. These bits select:

- the clock for each register;
- whether the pad bypasses the input register;
- whether the pad is driven by the state register or straight from the logic array;
- what the cell feeds back to the array;
- where the three-state enable comes from.

The array supplies five terms to each cell: two data terms combined by exclusive-OR, a set term, a reset term and an output-enable term. With the data terms chosen suitably, the state register behaves as a D, T, JK or RS element.

Each pair of cells also has a shared-input selector. It sends the input path of one of the two cells to a dedicated array input, so that a pin whose cell is used as hidden state can still be read.

All logic runs on one core clock. The two state clocks and the two input clocks enter as single-cycle enable strobes on that clock. A register updates only on a core edge where its selected strobe is high. The configuration inputs are treated as static once reset is released.

Top module: `mcell_pair_array`

## Requirements
- R1: After reset the state and input registers of every cell are 0, so with every configuration bit at 0 each pad output and each feedback output reads 0.
- R2: Configuration bit cfg_oe_sel (per cell): 0 drives pad_oe from the cell's pt_oe term, 1 drives it from the global oe_pin.
- R3: Configuration bit cfg_fb_sel: 0 sends the state register to fb_to_array, 1 sends the cell's input path.
- R4: Configuration bit cfg_iclk_sel: 0 clocks the input register on edges where iclk1_en is high, 1 on edges where iclk2_en is high; the register captures pad_in.
- R5: Configuration bit cfg_in_byp: 0 takes the input path from the input register, 1 takes it straight from pad_in.
- R6: Configuration bit cfg_out_byp: 0 drives pad_out from the state register, 1 from pt_d0 XOR pt_d1 combinationally.
- R7: Configuration bit cfg_sclk_sel: 0 clocks the state register on edges where sclk1_en is high, 1 on edges where sclk2_en is high.
- R8: On a selected state edge with neither set nor reset term high, the state register loads pt_d0 XOR pt_d1.
- R9: On a selected state edge, a high pt_rst clears the state register and a high pt_set sets it; when both are high, clear wins.
- R10: On an edge where its selected strobe is low, a register holds its value, whatever the data, set and reset terms do.
- R11: For pair p (cells 2p as A and 2p+1 as B), cfg_pair_sel[p] = 0 puts cell A's input path on shared_to_array[p], and 1 puts cell B's.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sclk1_en | input | 1 | State clock 1 strobe |
| sclk2_en | input | 1 | State clock 2 strobe |
| iclk1_en | input | 1 | Input clock 1 strobe |
| iclk2_en | input | 1 | Input clock 2 strobe |
| oe_pin | input | 1 | Global output-enable pin |
| cfg_oe_sel | input | CELLS | Enable source per cell (R2) |
| cfg_fb_sel | input | CELLS | Feedback source per cell (R3) |
| cfg_iclk_sel | input | CELLS | Input register clock per cell (R4) |
| cfg_in_byp | input | CELLS | Input register bypass per cell (R5) |
| cfg_out_byp | input | CELLS | Output register bypass per cell (R6) |
| cfg_sclk_sel | input | CELLS | State register clock per cell (R7) |
| cfg_pair_sel | input | PAIRS | Shared-input selection per pair (R11) |
| pt_d0 | input | CELLS | First data term |
| pt_d1 | input | CELLS | Second data term, XORed with the first |
| pt_set | input | CELLS | Synchronous set term |
| pt_rst | input | CELLS | Synchronous reset term |
| pt_oe | input | CELLS | Output-enable term |
| pad_in | input | CELLS | Value seen on the pad |
| pad_out | output | CELLS | Value driven toward the pad |
| pad_oe | output | CELLS | Three-state enable of the pad driver |
| fb_to_array | output | CELLS | Feedback to the logic array |
| shared_to_array | output | PAIRS | Shared array input per pair |

## Verification
The hardest case to reach from the ports is one where the two registers of a cell move on different strobes while the configuration makes one of them invisible. An example is an input register that changes under the input bypass, or a state register that changes under the output bypass and input feedback.

The stimulus drives all four strobes independently at random for every cell, with per-cell configurations drawn afresh in each phase. A behavioural model tracks both registers at all times. When a later phase exposes a register, its hidden history is therefore checked as well.

One phase raises set and reset together often, to hit the clear-wins case. Another holds every strobe low, to show that the registers hold.

// File: rtl/mcell_pkg.sv
package mcell_pkg;

  // Static architecture selection of one cell; 0 is the erased default.
  typedef struct packed {
    logic oe_pin_sel;   // enable from global pin
    logic fb_in_sel;    // feedback from input path
    logic iclk_sel;     // input register on input clock 2
    logic in_bypass;    // pad straight to input path
    logic out_bypass;   // array sum straight to pad
    logic sclk_sel;     // state register on state clock 2
  } cell_cfg_t;

endpackage

// File: rtl/mcell_in_path.sv
module mcell_in_path (
  input  logic clk,
  input  logic rst_n,
  input  logic iclk1_en,
  input  logic iclk2_en,
  input  logic iclk_sel,
  input  logic in_bypass,
  input  logic pad_in,
  output logic in_path
);

  logic cap_en;
  logic ireg_q;
  logic ireg_d;

  always_comb begin
    cap_en = iclk_sel ? iclk2_en : iclk1_en;
    ireg_d = cap_en ? pad_in : ireg_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ireg_q <= 1'b0;
    else        ireg_q <= ireg_d;
  end

  assign in_path = in_bypass ? pad_in : ireg_q;

  // R4: selected input strobe captures the pad
  p_in_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cap_en |=> (ireg_q == $past(pad_in)));

  // R10: no selected strobe, no change
  p_in_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_en |=> $stable(ireg_q));

endmodule

// File: rtl/mcell_state.sv
module mcell_state (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk1_en,
  input  logic sclk2_en,
  input  logic sclk_sel,
  input  logic d0,
  input  logic d1,
  input  logic set_t,
  input  logic rst_t,
  output logic q,
  output logic dsum
);

  logic st_en;
  logic st_d;

  always_comb begin
    dsum  = d0 ^ d1;
    st_en = sclk_sel ? sclk2_en : sclk1_en;
    st_d  = q;
    if (st_en) begin
      if (rst_t)      st_d = 1'b0;
      else if (set_t) st_d = 1'b1;
      else            st_d = dsum;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= st_d;
  end

  // R9: clear has priority over set
  p_clear_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_en && rst_t) |=> !q);

  // R9: set alone forces one
  p_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_en && set_t && !rst_t) |=> q);

  // R8: plain edge loads the XOR of the data terms
  p_xor_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_en && !set_t && !rst_t) |=> (q == ($past(d0) ^ $past(d1))));

  // R10: unselected edge holds
  p_state_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !st_en |=> $stable(q));

endmodule

// File: rtl/mcell_io_cell.sv
module mcell_io_cell
  import mcell_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      sclk1_en,
  input  logic      sclk2_en,
  input  logic      iclk1_en,
  input  logic      iclk2_en,
  input  logic      oe_pin,
  input  cell_cfg_t cfg,
  input  logic      pt_d0,
  input  logic      pt_d1,
  input  logic      pt_set,
  input  logic      pt_rst,
  input  logic      pt_oe,
  input  logic      pad_in,
  output logic      pad_out,
  output logic      pad_oe,
  output logic      fb_out,
  output logic      in_path
);

  logic state_q;
  logic sum_t;

  mcell_state u_state (
    .clk      (clk),
    .rst_n    (rst_n),
    .sclk1_en (sclk1_en),
    .sclk2_en (sclk2_en),
    .sclk_sel (cfg.sclk_sel),
    .d0       (pt_d0),
    .d1       (pt_d1),
    .set_t    (pt_set),
    .rst_t    (pt_rst),
    .q        (state_q),
    .dsum     (sum_t)
  );

  mcell_in_path u_in (
    .clk       (clk),
    .rst_n     (rst_n),
    .iclk1_en  (iclk1_en),
    .iclk2_en  (iclk2_en),
    .iclk_sel  (cfg.iclk_sel),
    .in_bypass (cfg.in_bypass),
    .pad_in    (pad_in),
    .in_path   (in_path)
  );

  always_comb begin
    pad_out = cfg.out_bypass ? sum_t : state_q;
    pad_oe  = cfg.oe_pin_sel ? oe_pin : pt_oe;
    fb_out  = cfg.fb_in_sel ? in_path : state_q;
  end

endmodule

// File: rtl/mcell_share.sv
module mcell_share (
  input  logic in_a,
  input  logic in_b,
  input  logic sel_b,
  output logic y
);

  assign y = sel_b ? in_b : in_a;

endmodule

// File: rtl/mcell_pair_array.sv
module mcell_pair_array
  import mcell_pkg::*;
#(
  parameter int PAIRS = 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sclk1_en,
  input  logic               sclk2_en,
  input  logic               iclk1_en,
  input  logic               iclk2_en,
  input  logic               oe_pin,
  input  logic [2*PAIRS-1:0] cfg_oe_sel,
  input  logic [2*PAIRS-1:0] cfg_fb_sel,
  input  logic [2*PAIRS-1:0] cfg_iclk_sel,
  input  logic [2*PAIRS-1:0] cfg_in_byp,
  input  logic [2*PAIRS-1:0] cfg_out_byp,
  input  logic [2*PAIRS-1:0] cfg_sclk_sel,
  input  logic [PAIRS-1:0]   cfg_pair_sel,
  input  logic [2*PAIRS-1:0] pt_d0,
  input  logic [2*PAIRS-1:0] pt_d1,
  input  logic [2*PAIRS-1:0] pt_set,
  input  logic [2*PAIRS-1:0] pt_rst,
  input  logic [2*PAIRS-1:0] pt_oe,
  input  logic [2*PAIRS-1:0] pad_in,
  output logic [2*PAIRS-1:0] pad_out,
  output logic [2*PAIRS-1:0] pad_oe,
  output logic [2*PAIRS-1:0] fb_to_array,
  output logic [PAIRS-1:0]   shared_to_array
);

  localparam int CELLS = 2 * PAIRS;

  // Reset: asserts at once, releases after SYNC_STAGES core edges.
  logic [SYNC_STAGES-1:0] rst_pipe_q;
  logic [SYNC_STAGES-1:0] rst_pipe_d;
  logic                   core_rst_n;

  always_comb rst_pipe_d = {rst_pipe_q[SYNC_STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= rst_pipe_d;
  end

  assign core_rst_n = rst_pipe_q[SYNC_STAGES-1];

  logic [CELLS-1:0] in_path;

  for (genvar c = 0; c < CELLS; c++) begin : g_cell
    cell_cfg_t cfg_c;

    always_comb begin
      cfg_c.oe_pin_sel = cfg_oe_sel[c];
      cfg_c.fb_in_sel  = cfg_fb_sel[c];
      cfg_c.iclk_sel   = cfg_iclk_sel[c];
      cfg_c.in_bypass  = cfg_in_byp[c];
      cfg_c.out_bypass = cfg_out_byp[c];
      cfg_c.sclk_sel   = cfg_sclk_sel[c];
    end

    mcell_io_cell u_cell (
      .clk      (clk),
      .rst_n    (core_rst_n),
      .sclk1_en (sclk1_en),
      .sclk2_en (sclk2_en),
      .iclk1_en (iclk1_en),
      .iclk2_en (iclk2_en),
      .oe_pin   (oe_pin),
      .cfg      (cfg_c),
      .pt_d0    (pt_d0[c]),
      .pt_d1    (pt_d1[c]),
      .pt_set   (pt_set[c]),
      .pt_rst   (pt_rst[c]),
      .pt_oe    (pt_oe[c]),
      .pad_in   (pad_in[c]),
      .pad_out  (pad_out[c]),
      .pad_oe   (pad_oe[c]),
      .fb_out   (fb_to_array[c]),
      .in_path  (in_path[c])
    );
  end

  for (genvar p = 0; p < PAIRS; p++) begin : g_pair
    mcell_share u_share (
      .in_a  (in_path[2*p]),
      .in_b  (in_path[2*p+1]),
      .sel_b (cfg_pair_sel[p]),
      .y     (shared_to_array[p])
    );
  end

  // R1: during core reset, a default-configured cell shows no stored one
  p_reset_low_r1: assert property (@(posedge clk)
    (!core_rst_n && (cfg_out_byp == '0)) |-> (pad_out == '0));

endmodule

// File: tb/mcell_pair_array_bench.sv
module mcell_pair_array_bench;

  localparam int PAIRS = 2;
  localparam int CELLS = 2 * PAIRS;

  logic clk = 1'b0;
  logic rst_n;
  logic sclk1_en, sclk2_en, iclk1_en, iclk2_en, oe_pin;
  logic [CELLS-1:0] cfg_oe_sel, cfg_fb_sel, cfg_iclk_sel, cfg_in_byp, cfg_out_byp, cfg_sclk_sel;
  logic [PAIRS-1:0] cfg_pair_sel;
  logic [CELLS-1:0] pt_d0, pt_d1, pt_set, pt_rst, pt_oe, pad_in;
  logic [CELLS-1:0] pad_out, pad_oe, fb_to_array;
  logic [PAIRS-1:0] shared_to_array;

  always #10 clk = ~clk;

  mcell_pair_array #(.PAIRS(PAIRS)) u_mcell_pair_array (
    .clk(clk), .rst_n(rst_n),
    .sclk1_en(sclk1_en), .sclk2_en(sclk2_en), .iclk1_en(iclk1_en), .iclk2_en(iclk2_en),
    .oe_pin(oe_pin),
    .cfg_oe_sel(cfg_oe_sel), .cfg_fb_sel(cfg_fb_sel), .cfg_iclk_sel(cfg_iclk_sel),
    .cfg_in_byp(cfg_in_byp), .cfg_out_byp(cfg_out_byp), .cfg_sclk_sel(cfg_sclk_sel),
    .cfg_pair_sel(cfg_pair_sel),
    .pt_d0(pt_d0), .pt_d1(pt_d1), .pt_set(pt_set), .pt_rst(pt_rst), .pt_oe(pt_oe),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .fb_to_array(fb_to_array), .shared_to_array(shared_to_array)
  );

  int n_tests = 0;
  int n_fail  = 0;
  string cur_req = "R1";

  // Reference state
  bit m_state [CELLS];
  bit m_ireg  [CELLS];
  int edges_since_release = 0;

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string what);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  // Apply one core edge to the model with the inputs that were present at it.
  task automatic model_edge();
    bit live;
    live = (edges_since_release >= 2);
    if (rst_n) edges_since_release++;
    else       edges_since_release = 0;
    for (int c = 0; c < CELLS; c++) begin
      bit s_en, i_en;
      if (!live) begin
        m_state[c] = 1'b0;
        m_ireg[c]  = 1'b0;
        continue;
      end
      s_en = cfg_sclk_sel[c] ? sclk2_en : sclk1_en;
      i_en = cfg_iclk_sel[c] ? iclk2_en : iclk1_en;
      if (s_en) begin
        if (pt_rst[c])      m_state[c] = 1'b0;
        else if (pt_set[c]) m_state[c] = 1'b1;
        else                m_state[c] = pt_d0[c] ^ pt_d1[c];
      end
      if (i_en) m_ireg[c] = pad_in[c];
    end
  endtask

  task automatic compare_all();
    logic [7:0] e_out, e_oe, e_fb, e_sh;
    bit ip [CELLS];
    e_out = '0; e_oe = '0; e_fb = '0; e_sh = '0;
    for (int c = 0; c < CELLS; c++) begin
      ip[c]    = cfg_in_byp[c] ? pad_in[c] : m_ireg[c];
      e_out[c] = cfg_out_byp[c] ? (pt_d0[c] ^ pt_d1[c]) : m_state[c];
      e_oe[c]  = cfg_oe_sel[c] ? oe_pin : pt_oe[c];
      e_fb[c]  = cfg_fb_sel[c] ? ip[c] : m_state[c];
    end
    for (int p = 0; p < PAIRS; p++) e_sh[p] = cfg_pair_sel[p] ? ip[2*p+1] : ip[2*p];
    check({4'b0, pad_out}, e_out, "pad_out");
    check({4'b0, pad_oe}, e_oe, "pad_oe");
    check({4'b0, fb_to_array}, e_fb, "fb_to_array");
    check({6'b0, shared_to_array}, e_sh, "shared_to_array");
  endtask

  // One cycle: model the edge just passed, drive new values, compare.
  task automatic cycle(input int set_pct, input bit strobes_on);
    @(negedge clk);
    model_edge();
    sclk1_en = strobes_on && ($urandom_range(0, 1) == 1);
    sclk2_en = strobes_on && ($urandom_range(0, 1) == 1);
    iclk1_en = strobes_on && ($urandom_range(0, 1) == 1);
    iclk2_en = strobes_on && ($urandom_range(0, 1) == 1);
    oe_pin   = 1'($urandom_range(0, 1));
    pt_d0    = CELLS'($urandom);
    pt_d1    = CELLS'($urandom);
    pt_oe    = CELLS'($urandom);
    pad_in   = CELLS'($urandom);
    for (int c = 0; c < CELLS; c++) begin
      pt_set[c] = ($urandom_range(0, 99) < set_pct);
      pt_rst[c] = ($urandom_range(0, 99) < set_pct);
    end
    #2;
    compare_all();
  endtask

  task automatic set_cfg(input logic [CELLS-1:0] oe, fb, ic, ib, ob, sc, input logic [PAIRS-1:0] ps);
    cfg_oe_sel = oe; cfg_fb_sel = fb; cfg_iclk_sel = ic;
    cfg_in_byp = ib; cfg_out_byp = ob; cfg_sclk_sel = sc; cfg_pair_sel = ps;
  endtask

  task automatic idle_inputs();
    {sclk1_en, sclk2_en, iclk1_en, iclk2_en, oe_pin} = '0;
    pt_d0 = '0; pt_d1 = '0; pt_set = '0; pt_rst = '0; pt_oe = '0; pad_in = '0;
  endtask

  initial begin
    #3_000_000;
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    idle_inputs();
    set_cfg('0, '0, '0, '0, '0, '0, '0);
    for (int c = 0; c < CELLS; c++) begin m_state[c] = 0; m_ireg[c] = 0; end

    // R1: outputs low during and just after reset, with set terms asserted
    cur_req = "R1";
    pt_set = '1;
    sclk1_en = 1'b1;
    iclk1_en = 1'b1;
    pad_in = '1;
    repeat (3) @(negedge clk);
    check({4'b0, pad_out}, 8'h00, "pad_out in reset");
    check({4'b0, fb_to_array}, 8'h00, "fb in reset");
    idle_inputs();
    rst_n = 1'b1;
    edges_since_release = 0;
    #2;
    compare_all();
    repeat (2) cycle(0, 1'b0);
    check({4'b0, pad_out}, 8'h00, "pad_out after release");

    // R9: set, then set and clear together on state clock 1
    cur_req = "R9";
    @(negedge clk);
    model_edge();
    idle_inputs();
    sclk1_en = 1'b1;
    pt_set = '1;
    @(negedge clk);
    model_edge();
    check({4'b0, pad_out}, 8'h0F, "pad_out after set");
    pt_rst = '1;
    @(negedge clk);
    model_edge();
    check({4'b0, pad_out}, 8'h00, "pad_out clear wins");
    idle_inputs();
    #2;
    compare_all();

    // Randomised phases, one per requirement, configuration drawn per phase
    for (int ph = 2; ph <= 11; ph++) begin
      int spct;
      bit on;
      spct = 10;
      on = 1'b1;
      case (ph)
        2:  cur_req = "R2";
        3:  cur_req = "R3";
        4:  cur_req = "R4";
        5:  cur_req = "R5";
        6:  cur_req = "R6";
        7:  cur_req = "R7";
        8:  begin cur_req = "R8"; spct = 0; end
        9:  begin cur_req = "R9"; spct = 60; end
        10: begin cur_req = "R10"; on = 1'b0; spct = 50; end
        default: cur_req = "R11";
      endcase
      for (int rep = 0; rep < 4; rep++) begin
        set_cfg(CELLS'($urandom), CELLS'($urandom), CELLS'($urandom), CELLS'($urandom),
                CELLS'($urandom), CELLS'($urandom), PAIRS'($urandom));
        #1;
        compare_all();
        repeat (60) cycle(spct, on);
      end
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule